// File: doc/BRIEF.md
# Display Data Channel Slave Byte Engine

This block is the byte-level slave side of a two-wire display data link. An external master drives the clock line and the data line. The block follows both lines and recognises START and STOP. It matches the first byte after START against a programmable 7-bit address. After a match it receives bytes from the master or sends bytes to it, with the acknowledge on the ninth clock. The pads are open-drain, so the block drives each line only through an active-high pull-low enable.

Each direction has a shift register and one holding register. While the host keeps up, the bus runs at the master's pace. The block holds the clock line low only when a received byte has nowhere to go because the holding register is still unread, or when nothing is left to send because both transmit registers are empty. A host sees four sticky status flags, clears each by writing 1 to it, and gets one interrupt line gated by a per-flag enable.

The link controller is a state machine:
- `LS_IDLE` and `LS_SKIP` wait for a bus condition.
- `LS_ADDR` shifts in the address byte.
- `LS_ADDR_ACK` drives the address acknowledge.
- `LS_RX_BITS`, `LS_RX_ACK` and `LS_RX_HOLD` receive a byte, acknowledge it, and stretch the clock while the holding register is full.
- `LS_TX_BITS`, `LS_TX_ACK` and `LS_TX_HOLD` send a byte, sample the master's acknowledge, and stretch the clock while no data is waiting.

The transitions are:
- A STOP takes any state to `LS_IDLE`.
- A START takes any state to `LS_ADDR`, or to `LS_IDLE` when the alternative mode is selected.
- `LS_ADDR` goes to `LS_ADDR_ACK` on an address hit and to `LS_SKIP` on a miss.
- `LS_ADDR_ACK` goes to `LS_RX_BITS`, `LS_TX_BITS` or `LS_TX_HOLD`, depending on the R/W bit and the transmit buffer.
- `LS_RX_BITS` goes to `LS_RX_ACK`.
- `LS_RX_ACK` goes to `LS_RX_BITS`, or to `LS_RX_HOLD` when the holding register is full. `LS_RX_HOLD` goes to `LS_RX_BITS` once the host reads.
- `LS_TX_BITS` goes to `LS_TX_ACK`.
- `LS_TX_ACK` goes to `LS_TX_BITS`, to `LS_TX_HOLD` when no byte is waiting, or to `LS_SKIP` on a no-acknowledge. `LS_TX_HOLD` goes to `LS_TX_BITS` once the host writes.

Top module: `ddc_slave_engine`

## Requirements
- R1: After reset, `scl_oe`, `sda_oe`, `flags`, `irq` and `mode_alt` are all 0.
- R2: The first byte after a START is taken MSB first. Bits 7..1 are the address and bit 0 is R/W, where 0 means the master writes. When the address equals `own_addr`, the block pulls SDA low during the ninth clock.
- R3: When the address differs from `own_addr`, the block leaves SDA released, including every ninth clock, until the next START or STOP.
- R4: Received bytes appear MSB first on `rx_data`, and `flags[0]` (receive done) is set at the falling edge of the ninth clock. With `nak_sel`=0 the ninth-clock SDA is pulled low. With `nak_sel`=1 it stays released.
- R5: If a received byte completes while the holding register is still unread, `scl_oe` is asserted from the ninth-clock fall. `rx_data` keeps the old byte. After an `rx_rd` pulse, the clock is released and `rx_data` shows the new byte.
- R6: When R/W=1, at each ninth-clock fall the transmit holding register is copied into the shift register and `flags[1]` (transmit request) is set. The byte goes out MSB first.
- R7: If the transmit holding register is empty at the ninth-clock fall after an acknowledge, `scl_oe` is held. A `tx_wr` releases it, and that byte is loaded, sets `flags[1]` again, and is sent next.
- R8: If the master's ninth-clock bit after a transmitted byte is high, `flags[2]` (no-acknowledge) is set. It stays 0 after an acknowledge.
- R9: An SDA rise while SCL is high (STOP) sets `flags[3]` and returns the controller to idle.
- R10: The flags are sticky. A 1 in bit n of `flag_clr` clears only `flags[n]`.
- R11: `irq` is the OR of `flags & irq_en`.
- R12: `mode_alt` follows `mode_req` only while the controller is idle and SCL is high. While `mode_alt`=1, a START is ignored and no acknowledge is given.
- R13: The block changes its SDA drive only while SCL is low, so SDA is stable for the whole high phase of every clock it drives.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, at least 8x the SCL rate |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_in | input | 1 | Clock line level as seen at the pad |
| sda_in | input | 1 | Data line level as seen at the pad |
| scl_oe | output | 1 | Pull SCL low (clock stretch) |
| sda_oe | output | 1 | Pull SDA low |
| own_addr | input | 7 | Slave address |
| nak_sel | input | 1 | 1 = answer received bytes with no-acknowledge |
| tx_wr | input | 1 | Write pulse for the transmit holding register |
| tx_data | input | 8 | Byte written by `tx_wr` |
| rx_rd | input | 1 | Read pulse that frees the receive holding register |
| rx_data | output | 8 | Receive holding register |
| flag_clr | input | 4 | Write-1-to-clear strobes, one per flag |
| flags | output | 4 | [0] receive done, [1] transmit request, [2] no-acknowledge, [3] stop |
| irq_en | input | 4 | Interrupt enable per flag |
| irq | output | 1 | Interrupt request |
| mode_req | input | 1 | Request for the alternative channel mode |
| mode_alt | output | 1 | Alternative channel mode accepted |

## Verification
The bench acts as a bus master on wired-AND lines. It sends address bytes that hit and miss, and telling them apart shows whether the match and the R/W split work. Write bytes are sent with the host reading promptly and with the host late, which separates normal acknowledge from clock stretching and shows that `nak_sel` changes only the ninth bit. Read transfers are run with the next byte preloaded and with it missing, and ended with either an acknowledge or a no-acknowledge. These patterns separate the transmit-request timing, the transmit stretch and the no-acknowledge flag. A mode request made during a transfer and again after STOP shows whether the idle gating works.

// File: rtl/ddc_pkg.sv
package ddc_pkg;

    localparam int NUM_FLAGS = 4;
    localparam int FLAG_RXD  = 0;
    localparam int FLAG_TXR  = 1;
    localparam int FLAG_NAK  = 2;
    localparam int FLAG_STP  = 3;

    typedef enum logic [3:0] {
        LS_IDLE,
        LS_ADDR,
        LS_ADDR_ACK,
        LS_RX_BITS,
        LS_RX_ACK,
        LS_RX_HOLD,
        LS_TX_BITS,
        LS_TX_ACK,
        LS_TX_HOLD,
        LS_SKIP
    } link_state_t;

endpackage

// File: rtl/ddc_bus_sync.sv
module ddc_bus_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_in,
    input  logic sda_in,
    output logic scl_lvl,
    output logic sda_lvl,
    output logic scl_rise,
    output logic scl_fall,
    output logic start_ev,
    output logic stop_ev
);

    logic [STAGES-1:0] scl_sh;
    logic [STAGES-1:0] sda_sh;
    logic              scl_q;
    logic              sda_q;

    generate
        if (STAGES == 1) begin : g_one
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    scl_sh <= '1;
                    sda_sh <= '1;
                end else begin
                    scl_sh <= scl_in;
                    sda_sh <= sda_in;
                end
            end
        end else begin : g_many
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    scl_sh <= '1;
                    sda_sh <= '1;
                end else begin
                    scl_sh <= {scl_sh[STAGES-2:0], scl_in};
                    sda_sh <= {sda_sh[STAGES-2:0], sda_in};
                end
            end
        end
    endgenerate

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            scl_q <= 1'b1;
            sda_q <= 1'b1;
        end else begin
            scl_q <= scl_sh[STAGES-1];
            sda_q <= sda_sh[STAGES-1];
        end
    end

    assign scl_lvl  = scl_sh[STAGES-1];
    assign sda_lvl  = sda_sh[STAGES-1];
    assign scl_rise = scl_lvl & ~scl_q;
    assign scl_fall = ~scl_lvl & scl_q;
    assign start_ev = scl_lvl & scl_q & sda_q & ~sda_lvl;
    assign stop_ev  = scl_lvl & scl_q & ~sda_q & sda_lvl;

endmodule

// File: rtl/ddc_link_fsm.sv
module ddc_link_fsm
    import ddc_pkg::*;
#(
    parameter int DATA_W = 8,
    parameter int ADDR_W = 7
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              scl_rise,
    input  logic              scl_fall,
    input  logic              sda_lvl,
    input  logic              start_ev,
    input  logic              stop_ev,
    input  logic [ADDR_W-1:0] own_addr,
    input  logic              nak_sel,
    input  logic              alt_mode,
    input  logic              rx_full,
    input  logic              tx_full,
    input  logic [DATA_W-1:0] tx_byte,
    output logic              rx_load,
    output logic [DATA_W-1:0] rx_byte,
    output logic              tx_take,
    output logic              nak_ev,
    output logic              scl_oe,
    output logic              sda_oe,
    output logic              idle
);

    localparam int               CNT_W    = $clog2(DATA_W + 1);
    localparam logic [CNT_W-1:0] FULL_CNT = CNT_W'(DATA_W);

    link_state_t       state;
    link_state_t       nxt;
    logic [CNT_W-1:0]  cnt;
    logic [DATA_W-1:0] shreg;
    logic              rw_q;
    logic              ack_q;
    logic              mack_hi;
    logic              byte_done;
    logic              addr_hit;
    logic              shift_in_st;

    assign byte_done   = (cnt == FULL_CNT);
    assign addr_hit    = (shreg[DATA_W-1 -: ADDR_W] == own_addr);
    assign shift_in_st = (state == LS_ADDR) || (state == LS_RX_BITS);

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= LS_IDLE;
        else        state <= nxt;
    end

    // next state
    always_comb begin
        nxt = state;
        if (stop_ev) begin
            nxt = LS_IDLE;
        end else if (start_ev) begin
            nxt = alt_mode ? LS_IDLE : LS_ADDR;
        end else begin
            unique case (state)
                LS_IDLE:     nxt = LS_IDLE;
                LS_ADDR:     if (scl_fall && byte_done)
                                 nxt = addr_hit ? LS_ADDR_ACK : LS_SKIP;
                LS_ADDR_ACK: if (scl_fall)
                                 nxt = !rw_q ? LS_RX_BITS
                                     : (tx_full ? LS_TX_BITS : LS_TX_HOLD);
                LS_RX_BITS:  if (scl_fall && byte_done) nxt = LS_RX_ACK;
                LS_RX_ACK:   if (scl_fall)
                                 nxt = rx_full ? LS_RX_HOLD : LS_RX_BITS;
                LS_RX_HOLD:  if (!rx_full) nxt = LS_RX_BITS;
                LS_TX_BITS:  if (scl_fall && byte_done) nxt = LS_TX_ACK;
                LS_TX_ACK:   if (scl_fall)
                                 nxt = mack_hi ? LS_SKIP
                                     : (tx_full ? LS_TX_BITS : LS_TX_HOLD);
                LS_TX_HOLD:  if (tx_full) nxt = LS_TX_BITS;
                LS_SKIP:     nxt = LS_SKIP;
                default:     nxt = LS_IDLE;
            endcase
        end
    end

    // datapath: bit counter, shift register, captured bits
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt     <= '0;
            shreg   <= '0;
            rw_q    <= 1'b0;
            ack_q   <= 1'b0;
            mack_hi <= 1'b0;
        end else begin
            if (start_ev || stop_ev ||
                (nxt != state && (nxt == LS_ADDR || nxt == LS_RX_BITS || nxt == LS_TX_BITS)))
                cnt <= '0;
            else if (scl_rise && !byte_done && (shift_in_st || state == LS_TX_BITS))
                cnt <= cnt + CNT_W'(1);

            if (tx_take)
                shreg <= tx_byte;
            else if (scl_rise && !byte_done && shift_in_st)
                shreg <= {shreg[DATA_W-2:0], sda_lvl};
            else if (scl_fall && !byte_done && state == LS_TX_BITS)
                shreg <= {shreg[DATA_W-2:0], 1'b0};

            if (state == LS_ADDR && nxt == LS_ADDR_ACK) rw_q  <= shreg[0];
            if (state == LS_RX_BITS && nxt == LS_RX_ACK) ack_q <= !nak_sel;
            if (state == LS_TX_ACK && scl_rise)          mack_hi <= sda_lvl;
        end
    end

    // outputs
    always_comb begin
        rx_load = 1'b0;
        tx_take = 1'b0;
        nak_ev  = 1'b0;
        scl_oe  = 1'b0;
        sda_oe  = 1'b0;
        unique case (state)
            LS_ADDR_ACK: begin
                sda_oe  = 1'b1;
                tx_take = scl_fall && rw_q && tx_full;
            end
            LS_RX_ACK: begin
                sda_oe  = ack_q;
                rx_load = scl_fall && !rx_full;
            end
            LS_RX_HOLD: begin
                scl_oe  = 1'b1;
                rx_load = !rx_full;
            end
            LS_TX_BITS: sda_oe = !shreg[DATA_W-1];
            LS_TX_ACK: begin
                tx_take = scl_fall && !mack_hi && tx_full;
                nak_ev  = scl_fall && mack_hi;
            end
            LS_TX_HOLD: begin
                scl_oe  = 1'b1;
                tx_take = tx_full;
            end
            default: ;
        endcase
    end

    assign rx_byte = shreg;
    assign idle    = (state == LS_IDLE);

    assert_rx_release_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (state == LS_RX_HOLD && !rx_full && !start_ev && !stop_ev) |=> !scl_oe);

    assert_rx_load_empty_R5: assert property (@(posedge clk) disable iff (!rst_n)
        rx_load |-> !rx_full);

    assert_tx_release_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (state == LS_TX_HOLD && tx_full && !start_ev && !stop_ev) |=> !scl_oe);

    assert_tx_take_full_R6: assert property (@(posedge clk) disable iff (!rst_n)
        tx_take |-> tx_full);

endmodule

// File: rtl/ddc_slave_engine.sv
module ddc_slave_engine
    import ddc_pkg::*;
#(
    parameter int DATA_W      = 8,
    parameter int ADDR_W      = 7,
    parameter int SYNC_STAGES = 2
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 scl_in,
    input  logic                 sda_in,
    output logic                 scl_oe,
    output logic                 sda_oe,
    input  logic [ADDR_W-1:0]    own_addr,
    input  logic                 nak_sel,
    input  logic                 tx_wr,
    input  logic [DATA_W-1:0]    tx_data,
    input  logic                 rx_rd,
    output logic [DATA_W-1:0]    rx_data,
    input  logic [NUM_FLAGS-1:0] flag_clr,
    output logic [NUM_FLAGS-1:0] flags,
    input  logic [NUM_FLAGS-1:0] irq_en,
    output logic                 irq,
    input  logic                 mode_req,
    output logic                 mode_alt
);

    logic scl_lvl, sda_lvl, scl_rise, scl_fall, start_ev, stop_ev;
    logic rx_load, tx_take, nak_ev, idle;
    logic rx_full, tx_full;
    logic [DATA_W-1:0] rx_byte, rx_hold, tx_hold;
    logic [NUM_FLAGS-1:0] flag_set;

    ddc_bus_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .scl_in   (scl_in),
        .sda_in   (sda_in),
        .scl_lvl  (scl_lvl),
        .sda_lvl  (sda_lvl),
        .scl_rise (scl_rise),
        .scl_fall (scl_fall),
        .start_ev (start_ev),
        .stop_ev  (stop_ev)
    );

    ddc_link_fsm #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_fsm (
        .clk      (clk),
        .rst_n    (rst_n),
        .scl_rise (scl_rise),
        .scl_fall (scl_fall),
        .sda_lvl  (sda_lvl),
        .start_ev (start_ev),
        .stop_ev  (stop_ev),
        .own_addr (own_addr),
        .nak_sel  (nak_sel),
        .alt_mode (mode_alt),
        .rx_full  (rx_full),
        .tx_full  (tx_full),
        .tx_byte  (tx_hold),
        .rx_load  (rx_load),
        .rx_byte  (rx_byte),
        .tx_take  (tx_take),
        .nak_ev   (nak_ev),
        .scl_oe   (scl_oe),
        .sda_oe   (sda_oe),
        .idle     (idle)
    );

    // holding registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rx_hold <= '0;
            rx_full <= 1'b0;
            tx_hold <= '0;
            tx_full <= 1'b0;
        end else begin
            if (rx_load) begin
                rx_hold <= rx_byte;
                rx_full <= 1'b1;
            end else if (rx_rd) begin
                rx_full <= 1'b0;
            end
            if (tx_wr) begin
                tx_hold <= tx_data;
                tx_full <= 1'b1;
            end else if (tx_take) begin
                tx_full <= 1'b0;
            end
        end
    end

    // sticky flags, write 1 to clear, set wins
    always_comb begin
        flag_set           = '0;
        flag_set[FLAG_RXD] = rx_load;
        flag_set[FLAG_TXR] = tx_take;
        flag_set[FLAG_NAK] = nak_ev;
        flag_set[FLAG_STP] = stop_ev;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) flags <= '0;
        else        flags <= (flags & ~flag_clr) | flag_set;
    end

    // mode switch accepted only while idle with SCL released
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                mode_alt <= 1'b0;
        else if (idle && scl_lvl)  mode_alt <= mode_req;
    end

    assign rx_data = rx_hold;
    assign irq     = |(flags & irq_en);

    assert_sda_low_phase_R13: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(sda_oe) |-> !scl_lvl);

    assert_stop_sticky_R10: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(flags[FLAG_STP]) && !$past(flag_clr[FLAG_STP])) |-> flags[FLAG_STP]);

    assert_mode_gate_R12: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(mode_alt) |-> $past(idle && scl_lvl));

endmodule

// File: tb/ddc_slave_engine_test.sv
`timescale 1ns/1ps
module ddc_slave_engine_test;

    localparam int H = 20;
    localparam logic [6:0] OWN = 7'h50;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic scl_m = 1'b1, sda_m = 1'b1;
    logic scl_oe, sda_oe, scl_line, sda_line;
    logic nak_sel = 1'b0, tx_wr = 1'b0, rx_rd = 1'b0, mode_req = 1'b0;
    logic [7:0] tx_data = 8'h00;
    logic [7:0] rx_data;
    logic [3:0] flag_clr = 4'h0, irq_en = 4'h0, flags;
    logic irq, mode_alt;
    int n_chk = 0, n_fail = 0;

    always #4 clk = ~clk;

    assign scl_line = scl_m & ~scl_oe;
    assign sda_line = sda_m & ~sda_oe;

    ddc_slave_engine uut (
        .clk(clk), .rst_n(rst_n), .scl_in(scl_line), .sda_in(sda_line),
        .scl_oe(scl_oe), .sda_oe(sda_oe), .own_addr(OWN), .nak_sel(nak_sel),
        .tx_wr(tx_wr), .tx_data(tx_data), .rx_rd(rx_rd), .rx_data(rx_data),
        .flag_clr(flag_clr), .flags(flags), .irq_en(irq_en), .irq(irq),
        .mode_req(mode_req), .mode_alt(mode_alt)
    );

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic summary;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    endtask

    task automatic scl_high;
        scl_m = 1'b1;
        do tick(1); while (!scl_line);
    endtask

    task automatic bus_start;
        sda_m = 1'b1; tick(H);
        scl_high; tick(H);
        sda_m = 1'b0; tick(H);
        scl_m = 1'b0; tick(H);
    endtask

    task automatic bus_stop;
        scl_m = 1'b0; sda_m = 1'b0; tick(H);
        scl_high; tick(H);
        sda_m = 1'b1; tick(H);
    endtask

    task automatic put_byte(input logic [7:0] b, output logic ack);
        for (int i = 7; i >= 0; i--) begin
            sda_m = b[i]; tick(H);
            scl_high; tick(H);
            scl_m = 1'b0;
        end
        tick(2); sda_m = 1'b1; tick(H);
        scl_high; tick(H / 2);
        ack = sda_line;
        tick(H / 2);
        scl_m = 1'b0; tick(H / 2);
    endtask

    task automatic get_byte(input logic mack, output logic [7:0] d);
        logic first;
        sda_m = 1'b1;
        for (int i = 7; i >= 0; i--) begin
            tick(H);
            scl_high; tick(H / 2);
            d[i] = sda_line;
            first = sda_line;
            tick(H / 2);
            check("R13 sda stable while scl high", sda_line, first);
            scl_m = 1'b0;
        end
        tick(H / 4); sda_m = mack; tick(H);
        scl_high; tick(H);
        scl_m = 1'b0; tick(2);
        sda_m = 1'b1; tick(H / 2);
    endtask

    task automatic pulse_clr(input logic [3:0] m);
        flag_clr = m; tick(1); flag_clr = 4'h0; tick(1);
    endtask

    task automatic test_reset;
        check("R1 scl_oe", scl_oe, 0);
        check("R1 sda_oe", sda_oe, 0);
        check("R1 flags", flags, 0);
        check("R1 irq", irq, 0);
        check("R1 mode_alt", mode_alt, 0);
    endtask

    task automatic test_miss;
        logic a;
        bus_start;
        put_byte({7'h22, 1'b0}, a);
        check("R3 no ack on address miss", a, 1);
        put_byte(8'h00, a);
        check("R3 no ack on data after miss", a, 1);
        check("R3 no byte taken", flags[0], 0);
        bus_stop;
        tick(4);
        check("R9 stop flag", flags[3], 1);
        pulse_clr(4'hF);
    endtask

    task automatic test_write;
        logic a;
        bus_start;
        put_byte({OWN, 1'b0}, a);
        check("R2 address ack", a, 0);
        check("R4 address sets no rx flag", flags[0], 0);
        put_byte(8'hA5, a);
        check("R4 data ack", a, 0);
        check("R4 rx flag", flags[0], 1);
        check("R4 rx data", rx_data, 8'hA5);
        rx_rd = 1'b1; tick(1); rx_rd = 1'b0;
        pulse_clr(4'h1);
        nak_sel = 1'b1;
        put_byte(8'h3C, a);
        check("R4 nak_sel leaves SDA released", a, 1);
        check("R4 rx data after nak", rx_data, 8'h3C);
        nak_sel = 1'b0;
        rx_rd = 1'b1; tick(1); rx_rd = 1'b0;
        bus_stop;
        tick(4);
        check("R9 back to idle after stop", scl_oe, 0);
        pulse_clr(4'hF);
    endtask

    task automatic test_rx_stretch;
        logic a;
        bus_start;
        put_byte({OWN, 1'b0}, a);
        put_byte(8'h11, a);
        put_byte(8'h22, a);
        tick(10);
        check("R5 clock held while holding full", scl_oe, 1);
        check("R5 old byte kept", rx_data, 8'h11);
        pulse_clr(4'h1);
        rx_rd = 1'b1; tick(1); rx_rd = 1'b0;
        tick(6);
        check("R5 clock released after read", scl_oe, 0);
        check("R5 new byte visible", rx_data, 8'h22);
        check("R5 rx flag on release", flags[0], 1);
        rx_rd = 1'b1; tick(1); rx_rd = 1'b0;
        bus_stop;
        tick(4);
        pulse_clr(4'hF);
    endtask

    task automatic test_tx;
        logic a;
        logic [7:0] d;
        tx_data = 8'hC3; tx_wr = 1'b1; tick(1); tx_wr = 1'b0;
        bus_start;
        put_byte({OWN, 1'b1}, a);
        check("R2 read address ack", a, 0);
        check("R6 tx request at address end", flags[1], 1);
        pulse_clr(4'h2);
        get_byte(1'b0, d);
        check("R6 first byte MSB first", d, 8'hC3);
        check("R8 no nak flag after ack", flags[2], 0);
        tick(10);
        check("R7 clock held with no data", scl_oe, 1);
        check("R7 no request while empty", flags[1], 0);
        tx_data = 8'h5A; tx_wr = 1'b1; tick(1); tx_wr = 1'b0;
        tick(6);
        check("R7 clock released after write", scl_oe, 0);
        check("R7 tx request again", flags[1], 1);
        get_byte(1'b1, d);
        check("R7 written byte sent", d, 8'h5A);
        tick(4);
        check("R8 nak flag", flags[2], 1);
        bus_stop;
        tick(4);
    endtask

    task automatic test_flags;
        check("R10 flags after read transfer", flags, 4'b1110);
        irq_en = 4'b0001; tick(1);
        check("R11 irq masked", irq, 0);
        irq_en = 4'b0100; tick(1);
        check("R11 irq on nak", irq, 1);
        pulse_clr(4'b0100);
        check("R10 only nak cleared", flags, 4'b1010);
        check("R11 irq drops", irq, 0);
        irq_en = 4'h0;
        pulse_clr(4'hF);
        check("R10 all cleared", flags, 0);
    endtask

    task automatic test_mode;
        logic a;
        bus_start;
        put_byte({OWN, 1'b0}, a);
        mode_req = 1'b1;
        tick(10);
        check("R12 refused during transfer", mode_alt, 0);
        bus_stop;
        tick(6);
        check("R12 accepted after stop", mode_alt, 1);
        bus_start;
        put_byte({OWN, 1'b0}, a);
        check("R12 start ignored in alt mode", a, 1);
        bus_stop;
        mode_req = 1'b0;
        tick(6);
        check("R12 back to normal", mode_alt, 0);
        pulse_clr(4'hF);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog expired");
        summary;
        $finish;
    end

    initial begin
        tick(5);
        test_reset;
        rst_n = 1'b1;
        tick(5);
        test_miss;
        test_write;
        test_rx_stretch;
        test_tx;
        test_flags;
        test_mode;
        summary;
        $finish;
    end

endmodule